// File: doc/BRIEF.md
# Triggered Pulse Width and Period Meter

This block measures one interval on a digital input once it has been armed. In width mode the interval is a single active pulse; in period mode it runs from one start of the active level to the next. An arming trigger, given either by a one-cycle software strobe or by an edge on an external pin of programmable polarity, makes the block wait for the next interval to begin. An interval that is already under way when the trigger arrives is never measured. While the interval runs, an up counter counts ticks of a selected timebase. When the interval ends, the count goes to a readback register.

After each result the block drops back to idle and measures nothing more until it is triggered again. Each completion produces a completion pulse of fixed length, counted in base clock cycles, and can also raise a held interrupt request. The timebase is either the base clock divided by a power of two or the rising edges of an external clock. Every asynchronous input passes through a synchronizer before it is used. The configuration inputs are expected to stay steady while a measurement is armed or running.

Top module: `tpm_meter`

## Requirements
- R1: While rst_n is low at a clock edge, rd_value, ovf_flag, done_pulse and irq all go to 0 at that edge.
- R2: An accepted trigger is either sw_trig high at a clock edge, or the synchronized ext_trig_in entering its active level. The active level is set by cfg_trig_pol: 2'b10 means active high and 2'b01 means active low. With cfg_trig_pol 2'b00 or 2'b11, ext_trig_in never triggers.
- R3: Once armed, the block starts measuring only at the next transition of the measured input into its active level. A pulse that is already active when the trigger arrives is skipped.
- R4: When cfg_period_mode is 0 (width mode), the result is the number of timebase ticks during which the measured input is active, from its start to its end.
- R5: When cfg_period_mode is 1 (period mode), the result is the number of timebase ticks from one start of the active level to the next start.
- R6: cfg_meas_pol selects the active level of meas_in: 2'b10 means active high and 2'b01 means active low. With 2'b00 or 2'b11 no interval ever starts or completes, and the block stays armed.
- R7: cfg_clk_sel sets the timebase. Codes 3'd0 to 3'd4 give one tick every 16, 8, 4, 2 and 1 base clock cycles. Code 3'd5 gives one tick per rising edge of the synchronized ext_clk_in. Codes 3'd6 and 3'd7 give no ticks, so the result is 0.
- R8: After a result is captured the block is idle, and later intervals are not measured until a new trigger is accepted. A trigger that arrives while the block is armed or measuring has no effect.
- R9: The count saturates at all ones. If a tick arrives when the count is already at all ones, ovf_flag is set with the result. ovf_flag is cleared when the next trigger is accepted.
- R10: done_pulse goes high at the same edge at which rd_value takes a new result and stays high for exactly PULSE_CYC cycles. A new result restarts the pulse.
- R11: If cfg_irq_en is high at completion, irq is set and stays high until irq_ack is sampled high. If cfg_irq_en is low, irq does not rise.
- R12: rd_value changes only when a result is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Synchronous reset, active low |
| meas_in | input | 1 | Asynchronous signal whose pulse or period is measured |
| ext_trig_in | input | 1 | Asynchronous external arming trigger |
| ext_clk_in | input | 1 | Asynchronous external timebase |
| sw_trig | input | 1 | One-cycle software arming strobe |
| cfg_period_mode | input | 1 | 0 selects width mode, 1 selects period mode |
| cfg_meas_pol | input | 2 | Active level of meas_in (01 low, 10 high, other codes disabled) |
| cfg_trig_pol | input | 2 | Active level of ext_trig_in (01 low, 10 high, other codes disabled) |
| cfg_clk_sel | input | SEL_W | Timebase select (0 to 4 internal division, 5 external, 6 and 7 none) |
| cfg_irq_en | input | 1 | Allows completion to raise irq |
| irq_ack | input | 1 | Clears irq |
| rd_value | output | CNT_W | Result of the last completed measurement |
| ovf_flag | output | 1 | The last result saturated |
| done_pulse | output | 1 | Completion pulse, PULSE_CYC cycles long |
| irq | output | 1 | Held interrupt request |

## Verification
The bench arms the block in the middle of an active pulse. A design that starts on the level instead of the edge would report the tail of that pulse rather than the next full pulse. It also triggers in the middle of a measurement and sends a second pulse with no new trigger; a design that re-arms would then overwrite the result. The bench drives a pulse longer than the counter can hold, which catches a counter that wraps to a small value or an overflow flag that does not survive until the next trigger. Further cases cover disabled polarity codes, every timebase code including the external clock and the codes with no ticks, the exact length of the completion pulse, and how irq is held and cleared.

// File: rtl/tpm_pkg.sv
// Package tpm_pkg
// Shared types and helpers for the triggered pulse meter.
// Assumes: polarity fields use 01 for active low and 10 for active high.
package tpm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_MEAS  = 2'd2
    } tpm_state_e;

    localparam logic [1:0] POL_LOW  = 2'b01;
    localparam logic [1:0] POL_HIGH = 2'b10;

    // Bit positions inside the synchronizer bundle
    localparam int IDX_MEAS = 0;
    localparam int IDX_TRIG = 1;
    localparam int IDX_XCLK = 2;
    localparam int N_SYNC   = 3;

    // Maps a raw level to "active" under a polarity code; disabled codes give 0
    function automatic logic pol_active(input logic [1:0] pol, input logic lvl);
        logic res;
        res = 1'b0;
        if (pol == POL_HIGH) res = lvl;
        else if (pol == POL_LOW) res = ~lvl;
        return res;
    endfunction

endpackage

// File: rtl/tpm_sync.sv
// Module tpm_sync
// Multi-bit synchronizer. Each bit has its own chain of STAGES flops plus
// one more flop that holds the previous synchronized level for edge detection.
// Assumes: each input bit is an independent level with no timing relation to clk.
module tpm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] prv
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES:0] chain_q;

        // Shifts the raw input through the sync stages and the history flop
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-1:0], din[g]};
        end

        assign lvl[g] = chain_q[STAGES-1];
        assign prv[g] = chain_q[STAGES];
    end

endmodule

// File: rtl/tpm_timebase.sv
// Module tpm_timebase
// Produces the counting tick. A free-running divider gives one tick every
// 2**(DIV_BITS-code) cycles for codes 0..DIV_BITS. Code DIV_BITS+1 passes the
// external clock rising edge. Any higher code gives no tick.
// Assumes: ext_rise is already synchronized and at most one cycle wide.
module tpm_timebase #(
    parameter int DIV_BITS = 4,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             ext_rise,
    output logic             tick
);

    localparam int N_RATES  = DIV_BITS + 1;
    localparam int EXT_CODE = DIV_BITS + 1;

    logic [DIV_BITS-1:0] div_q;
    logic [N_RATES-1:0]  rate_tick;

    // Free-running prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    // One tick candidate per division code: the kept low bits are all ones
    for (genvar c = 0; c < N_RATES; c++) begin : g_rate
        localparam logic [DIV_BITS-1:0] KEEP = {DIV_BITS{1'b1}} >> c;
        assign rate_tick[c] = &(div_q | ~KEEP);
    end

    // Selects the tick source from the clock-select code
    always_comb begin
        tick = 1'b0;
        for (int c = 0; c < N_RATES; c++) begin
            if (clk_sel == SEL_W'(c)) tick = rate_tick[c];
        end
        if (clk_sel == SEL_W'(EXT_CODE)) tick = ext_rise;
    end

endmodule

// File: rtl/tpm_meas_core.sv
// Module tpm_meas_core
// Sequencer and counter for one measurement. IDLE waits for a trigger.
// ARMED waits for the next start of the active level. MEAS counts ticks until
// the end of the pulse (width mode) or the next start (period mode), then
// reports the count and returns to IDLE.
// Assumes: act_start and act_end are one-cycle strobes from the synchronized input.
module tpm_meas_core
    import tpm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_period,
    input  logic             trig,
    input  logic             act_lvl,
    input  logic             act_start,
    input  logic             act_end,
    input  logic             tick,
    output logic             arm_o,
    output logic             cap_valid,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_ovf
);

    tpm_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sat_q;
    logic             stop_now;
    logic             count_en;

    assign stop_now = (state_q == ST_MEAS) && (mode_period ? act_start : act_end);
    assign count_en = tick && (mode_period || act_lvl);

    // State sequencing and saturating interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sat_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (trig) state_q <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (act_start) begin
                        state_q <= ST_MEAS;
                        cnt_q   <= {{(CNT_W-1){1'b0}}, tick};
                        sat_q   <= 1'b0;
                    end
                end
                ST_MEAS: begin
                    if (stop_now) begin
                        state_q <= ST_IDLE;
                    end else if (count_en) begin
                        if (&cnt_q) sat_q <= 1'b1;
                        else        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign arm_o     = (state_q == ST_IDLE) && trig;
    assign cap_valid = stop_now;
    assign cap_value = cnt_q;
    assign cap_ovf   = sat_q;

endmodule

// File: rtl/tpm_out_stage.sv
// Module tpm_out_stage
// Holds the readback result and overflow flag, stretches each completion into a
// pulse of PULSE_CYC cycles, and keeps the interrupt request until it is acknowledged.
// Assumes: cap_valid and arm never occur in the same cycle.
module tpm_out_stage #(
    parameter int CNT_W     = 16,
    parameter int PULSE_CYC = 175
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid,
    input  logic [CNT_W-1:0] cap_value,
    input  logic             cap_ovf,
    input  logic             arm,
    input  logic             irq_en,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] rd_value,
    output logic             ovf_flag,
    output logic             done_pulse,
    output logic             irq
);

    localparam int PC_W = $clog2(PULSE_CYC + 1);

    logic [CNT_W-1:0] rd_q;
    logic             ovf_q;
    logic             done_q;
    logic [PC_W-1:0]  pc_q;
    logic             irq_q;

    // Result register, loaded only on capture
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_q <= '0;
        else if (cap_valid) rd_q <= cap_value;
    end

    // Overflow flag: set with a saturated result, cleared on the next arm
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (cap_valid) ovf_q <= cap_ovf;
        else if (arm)       ovf_q <= 1'b0;
    end

    // Completion pulse stretcher
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            pc_q   <= '0;
        end else if (cap_valid) begin
            done_q <= 1'b1;
            pc_q   <= PC_W'(PULSE_CYC - 1);
        end else if (pc_q != '0) begin
            pc_q   <= pc_q - 1'b1;
        end else begin
            done_q <= 1'b0;
        end
    end

    // Held interrupt request; a new completion wins over an acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)                   irq_q <= 1'b0;
        else if (cap_valid && irq_en) irq_q <= 1'b1;
        else if (irq_ack)             irq_q <= 1'b0;
    end

    assign rd_value   = rd_q;
    assign ovf_flag   = ovf_q;
    assign done_pulse = done_q;
    assign irq        = irq_q;

endmodule

// File: rtl/tpm_meter.sv
// Module tpm_meter (top)
// Triggered pulse width / period meter. Synchronizes the measured input, the
// external trigger and the external clock, decodes the polarities, and passes
// the resulting strobes to the measurement core. The core's result goes to the
// output stage.
// Assumes: the configuration inputs are steady while the block is armed or measuring.
module tpm_meter
    import tpm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DIV_BITS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PULSE_CYC   = 175,
    localparam int SEL_W      = $clog2(DIV_BITS + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_in,
    input  logic             ext_trig_in,
    input  logic             ext_clk_in,
    input  logic             sw_trig,
    input  logic             cfg_period_mode,
    input  logic [1:0]       cfg_meas_pol,
    input  logic [1:0]       cfg_trig_pol,
    input  logic [SEL_W-1:0] cfg_clk_sel,
    input  logic             cfg_irq_en,
    input  logic             irq_ack,
    output logic [CNT_W-1:0] rd_value,
    output logic             ovf_flag,
    output logic             done_pulse,
    output logic             irq
);

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] s_lvl;
    logic [N_SYNC-1:0] s_prv;
    logic              act_now, act_was, act_start, act_end;
    logic              trg_now, trg_was, ext_hit, trig;
    logic              xclk_rise, tick;
    logic              arm;
    logic              cap_valid, cap_ovf;
    logic [CNT_W-1:0]  cap_value;

    always_comb begin
        raw_in           = '0;
        raw_in[IDX_MEAS] = meas_in;
        raw_in[IDX_TRIG] = ext_trig_in;
        raw_in[IDX_XCLK] = ext_clk_in;
    end

    tpm_sync #(
        .WIDTH  (N_SYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .lvl   (s_lvl),
        .prv   (s_prv)
    );

    // Polarity decode and edge strobes for the measured input and the trigger
    always_comb begin
        act_now   = pol_active(cfg_meas_pol, s_lvl[IDX_MEAS]);
        act_was   = pol_active(cfg_meas_pol, s_prv[IDX_MEAS]);
        act_start = act_now & ~act_was;
        act_end   = ~act_now & act_was;
        trg_now   = pol_active(cfg_trig_pol, s_lvl[IDX_TRIG]);
        trg_was   = pol_active(cfg_trig_pol, s_prv[IDX_TRIG]);
        ext_hit   = trg_now & ~trg_was;
        trig      = sw_trig | ext_hit;
        xclk_rise = s_lvl[IDX_XCLK] & ~s_prv[IDX_XCLK];
    end

    tpm_timebase #(
        .DIV_BITS (DIV_BITS),
        .SEL_W    (SEL_W)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_sel  (cfg_clk_sel),
        .ext_rise (xclk_rise),
        .tick     (tick)
    );

    tpm_meas_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_period (cfg_period_mode),
        .trig        (trig),
        .act_lvl     (act_now),
        .act_start   (act_start),
        .act_end     (act_end),
        .tick        (tick),
        .arm_o       (arm),
        .cap_valid   (cap_valid),
        .cap_value   (cap_value),
        .cap_ovf     (cap_ovf)
    );

    tpm_out_stage #(
        .CNT_W     (CNT_W),
        .PULSE_CYC (PULSE_CYC)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_valid  (cap_valid),
        .cap_value  (cap_value),
        .cap_ovf    (cap_ovf),
        .arm        (arm),
        .irq_en     (cfg_irq_en),
        .irq_ack    (irq_ack),
        .rd_value   (rd_value),
        .ovf_flag   (ovf_flag),
        .done_pulse (done_pulse),
        .irq        (irq)
    );

endmodule

// File: rtl/tpm_meter_chk.sv
// Module tpm_meter_chk
// Checker bound to tpm_meter. It relates the outputs to each other over time and
// uses a run-length counter to check the completion pulse length.
// Assumes: it sees only the top-level ports.
module tpm_meter_chk #(
    parameter int CNT_W     = 16,
    parameter int PULSE_CYC = 175
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_ack,
    input logic [CNT_W-1:0] rd_value,
    input logic             ovf_flag,
    input logic             done_pulse,
    input logic             irq
);

    localparam int RUN_W = $clog2(PULSE_CYC + 2);

    logic [RUN_W-1:0] run_q;

    // Counts consecutive high cycles of done_pulse, saturating at the top
    always_ff @(posedge clk) begin
        if (!rst_n)                     run_q <= '0;
        else if (!done_pulse)           run_q <= '0;
        else if (run_q != {RUN_W{1'b1}}) run_q <= run_q + 1'b1;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_value == '0 && !ovf_flag && !done_pulse && !irq));

    a_r12_value_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_value) |-> done_pulse);

    a_r9_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (&rd_value));

    a_r10_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_pulse) |-> (run_q >= RUN_W'(PULSE_CYC)));

    a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done_pulse);

    a_r11_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

endmodule

bind tpm_meter tpm_meter_chk #(
    .CNT_W     (CNT_W),
    .PULSE_CYC (PULSE_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_ack    (irq_ack),
    .rd_value   (rd_value),
    .ovf_flag   (ovf_flag),
    .done_pulse (done_pulse),
    .irq        (irq)
);

// File: tb/tpm_meter_tb_top.sv
module tpm_meter_tb_top;

    localparam int CNT_W     = 16;
    localparam int PULSE_CYC = 175;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        meas_in = 1'b0;
    logic        ext_trig_in = 1'b0;
    logic        ext_clk_in = 1'b0;
    logic        sw_trig = 1'b0;
    logic        cfg_period_mode = 1'b0;
    logic [1:0]  cfg_meas_pol = 2'b10;
    logic [1:0]  cfg_trig_pol = 2'b00;
    logic [2:0]  cfg_clk_sel = 3'd4;
    logic        cfg_irq_en = 1'b0;
    logic        irq_ack = 1'b0;
    logic [15:0] rd_value;
    logic        ovf_flag;
    logic        done_pulse;
    logic        irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    bit  act_hi = 1;

    always #5 clk = ~clk;

    tpm_meter #(
        .CNT_W     (CNT_W),
        .PULSE_CYC (PULSE_CYC)
    ) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .meas_in         (meas_in),
        .ext_trig_in     (ext_trig_in),
        .ext_clk_in      (ext_clk_in),
        .sw_trig         (sw_trig),
        .cfg_period_mode (cfg_period_mode),
        .cfg_meas_pol    (cfg_meas_pol),
        .cfg_trig_pol    (cfg_trig_pol),
        .cfg_clk_sel     (cfg_clk_sel),
        .cfg_irq_en      (cfg_irq_en),
        .irq_ack         (irq_ack),
        .rd_value        (rd_value),
        .ovf_flag        (ovf_flag),
        .done_pulse      (done_pulse),
        .irq             (irq)
    );

    typedef struct packed {
        logic        mode;
        logic [1:0]  pol;
        logic [2:0]  sel;
        logic [15:0] act;
        logic [15:0] idle;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'b10, 3'd4, 16'd37, 16'd20},
        '{1'b0, 2'b01, 3'd4, 16'd25, 16'd15},
        '{1'b1, 2'b10, 3'd4, 16'd12, 16'd30},
        '{1'b1, 2'b01, 3'd4, 16'd40, 16'd9},
        '{1'b0, 2'b10, 3'd0, 16'd64, 16'd20},
        '{1'b0, 2'b10, 3'd2, 16'd32, 16'd8},
        '{1'b1, 2'b10, 3'd3, 16'd10, 16'd14},
        '{1'b0, 2'b10, 3'd5, 16'd40, 16'd12},
        '{1'b1, 2'b10, 3'd1, 16'd24, 16'd16},
        '{1'b0, 2'b10, 3'd6, 16'd30, 16'd10}
    };

    // External clock: period of four base cycles, changed on falling edges
    initial begin
        forever begin
            repeat (2) @(negedge clk);
            ext_clk_in = ~ext_clk_in;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        n_chk++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic sw_pulse();
        sw_trig = 1'b1;
        cyc(1);
        sw_trig = 1'b0;
    endtask

    // Drives the measured input to its active (1) or inactive (0) level for n cycles
    task automatic drive(input bit active, input int n);
        meas_in = active ? act_hi : ~act_hi;
        cyc(n);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        int cnt_hi;
        bit seen;
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        check("R1 rd_value", rd_value, 0);
        check("R1 ovf_flag", ovf_flag, 0);
        check("R1 done_pulse", done_pulse, 0);
        check("R1 irq", irq, 0);

        // Table of vectors for R4, R5, R6 and R7
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            int len;
            int e;
            v = VECS[i];
            cfg_period_mode = v.mode;
            cfg_meas_pol    = v.pol;
            cfg_clk_sel     = v.sel;
            act_hi          = (v.pol == 2'b10);
            drive(0, 12);
            sw_pulse();
            drive(0, 6);
            drive(1, int'(v.act));
            drive(0, int'(v.idle));
            drive(1, int'(v.act));
            drive(0, int'(v.idle));
            cyc(10);
            len = v.mode ? int'(v.act) + int'(v.idle) : int'(v.act);
            if (v.sel <= 3'd4)      e = len >> (4 - int'(v.sel));
            else if (v.sel == 3'd5) e = len >> 2;
            else                    e = 0;
            check($sformatf("vec%0d %s R6 R7 result", i, v.mode ? "R5" : "R4"), rd_value, e);
            check($sformatf("vec%0d R10 done high", i), done_pulse, 1);
            cyc(200);
        end

        // R10, R11, R12: completion pulse length, irq hold and acknowledge
        cfg_period_mode = 1'b0;
        cfg_meas_pol    = 2'b10;
        cfg_clk_sel     = 3'd4;
        cfg_irq_en      = 1'b1;
        act_hi          = 1;
        drive(0, 10);
        sw_pulse();
        drive(0, 4);
        drive(1, 20);
        meas_in = 1'b0;
        cnt_hi = 0;
        seen = 0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (done_pulse) begin
                if (!seen) check("R12 value with done", rd_value, 20);
                seen = 1;
                cnt_hi++;
            end
        end
        check("R10 pulse length", cnt_hi, PULSE_CYC);
        check("R11 irq set", irq, 1);
        cyc(50);
        check("R11 irq held", irq, 1);
        irq_ack = 1'b1;
        cyc(1);
        irq_ack = 1'b0;
        check("R11 irq cleared", irq, 0);
        cfg_irq_en = 1'b0;
        sw_pulse();
        drive(0, 4);
        drive(1, 15);
        drive(0, 10);
        check("R4 width 15", rd_value, 15);
        check("R11 irq stays low when disabled", irq, 0);
        cyc(200);

        // R8: no new trigger, so the next pulse is not measured
        drive(0, 10);
        drive(1, 33);
        drive(0, 10);
        check("R8 no retrigger value", rd_value, 15);
        check("R8 no retrigger done", done_pulse, 0);

        // R8: a trigger during the measurement is ignored
        sw_pulse();
        drive(0, 5);
        drive(1, 15);
        sw_pulse();
        drive(1, 34);
        drive(0, 10);
        drive(1, 17);
        drive(0, 10);
        check("R8 mid-measure trigger ignored", rd_value, 50);
        cyc(200);

        // R3: arming during an active pulse skips that pulse
        drive(1, 10);
        sw_pulse();
        drive(1, 10);
        drive(0, 6);
        drive(1, 24);
        drive(0, 10);
        check("R3 next full pulse", rd_value, 24);
        cyc(200);

        // R2: external trigger, active high
        cfg_trig_pol = 2'b10;
        ext_trig_in  = 1'b1;
        cyc(3);
        ext_trig_in  = 1'b0;
        drive(0, 6);
        drive(1, 21);
        drive(0, 10);
        check("R2 ext trigger high", rd_value, 21);
        cyc(200);
        // R2: external trigger, active low
        cfg_trig_pol = 2'b01;
        cyc(5);
        ext_trig_in = 1'b1;
        cyc(8);
        ext_trig_in = 1'b0;
        cyc(3);
        ext_trig_in = 1'b1;
        drive(0, 6);
        drive(1, 19);
        drive(0, 10);
        check("R2 ext trigger low", rd_value, 19);
        cyc(200);
        // R2: disabled trigger polarity codes
        cfg_trig_pol = 2'b00;
        ext_trig_in  = 1'b0;
        cyc(4);
        ext_trig_in  = 1'b1;
        drive(0, 6);
        drive(1, 27);
        drive(0, 10);
        check("R2 code 00 ignored", rd_value, 19);
        cfg_trig_pol = 2'b11;
        ext_trig_in  = 1'b0;
        cyc(4);
        ext_trig_in  = 1'b1;
        drive(0, 6);
        drive(1, 23);
        drive(0, 10);
        check("R2 code 11 ignored", rd_value, 19);
        check("R2 no done", done_pulse, 0);
        cfg_trig_pol = 2'b00;
        ext_trig_in  = 1'b0;

        // R6: a disabled measured polarity never completes
        cfg_meas_pol = 2'b00;
        act_hi = 1;
        sw_pulse();
        drive(0, 5);
        drive(1, 30);
        drive(0, 10);
        check("R6 disabled polarity value", rd_value, 19);
        check("R6 disabled polarity done", done_pulse, 0);
        cfg_meas_pol = 2'b10;
        cyc(5);
        drive(1, 11);
        drive(0, 10);
        check("R6 stays armed then measures", rd_value, 11);
        cyc(200);

        // R9: saturation and overflow flag
        sw_pulse();
        drive(0, 4);
        drive(1, 70000);
        drive(0, 10);
        check("R9 saturated value", rd_value, 16'hFFFF);
        check("R9 overflow set", ovf_flag, 1);
        cyc(200);
        check("R9 overflow sticky", ovf_flag, 1);
        sw_pulse();
        cyc(2);
        check("R9 overflow cleared on arm", ovf_flag, 0);
        check("R12 value kept on arm", rd_value, 16'hFFFF);
        drive(1, 9);
        drive(0, 10);
        check("R9 small result after overflow", rd_value, 9);
        check("R9 no overflow", ovf_flag, 0);

        cyc(20);
        summary();
    end

endmodule